// File: doc/BRIEF.md
# Preamplifier Pushbutton Relay Controller

This block turns momentary pushbutton levels into the relay and indicator drive of an audio preamplifier. Four source buttons (tuner, aux, phono, phono with subsonic cut) share one latched selection, and exactly one source is held at any time. Two more buttons, tone and tape monitor, each flip their own stored state on every press. The inputs are synchronous button levels from an external debouncer. All stored state lives in clocked registers, and a press acts on its rising edge.

A power-up sequencer counts ticks of a slow timebase once power is reported good. It first lets the signal relays conduct and then, a few ticks later, releases the output mute. If power is lost, the relays drop and the mute returns at once, but the stored selections are kept. A reset request puts the panel into its preset state: tuner selected, tone off, tape monitor off. While the request is held the relays stay released and the mute stays applied.

Top module: `preamp_relay_ctrl`

## Requirements
- R1: Exactly one source is selected at all times. Selection bit 0 is tuner, bit 1 aux, bit 2 phono and bit 3 phono-subsonic. The state after `rst_n` is tuner.
- R2: A rising edge on one source button selects that source from the next clock cycle and deselects the other three.
- R3: Held, falling or static source buttons leave the selection unchanged.
- R4: When several source buttons rise in the same cycle, the lowest bit index wins.
- R5: Each rising edge on `btn_tone` or `btn_tape` inverts that state from the next cycle. The two states are independent of each other.
- R6: The drivers are active low. A driver output is 0 exactly when its state is 1 and the relays are enabled.
- R7: A cycle with `preset_req` high, or an asserted `rst_n`, sets the state to tuner with tone and tape monitor off. Button edges in that cycle are ignored.
- R8: With `pwr_good` high, the relays are enabled once `RELAY_TICKS` ticks have been counted since power became good.
- R9: `mute_on` falls once `UNMUTE_TICKS` ticks have been counted, where `UNMUTE_TICKS` > `RELAY_TICKS`. The mute is never released while the relays are disabled.
- R10: One cycle after `pwr_good` is sampled low, all drivers read 1 and `mute_on` reads 1. The selection and the toggle states are retained and reappear after the next power-up sequence.
- R11: From the cycle after `preset_req` is sampled high, the relays are disabled and the mute is applied. The tick count restarts from zero when the request is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_src | input | 4 | Source button levels, bit order as in R1 |
| btn_tone | input | 1 | Tone button level |
| btn_tape | input | 1 | Tape monitor button level |
| pwr_good | input | 1 | Supply is present and good |
| preset_req | input | 1 | Synchronous request for the preset state |
| tick_1hz | input | 1 | One-cycle timebase pulse |
| src_drv_n | output | 4 | Active-low source relay and lamp drivers |
| tone_drv_n | output | 1 | Active-low tone relay and lamp driver |
| tape_drv_n | output | 1 | Active-low tape monitor relay and lamp driver |
| mute_on | output | 1 | 1 = output held muted |

## Verification
A corrupted selection register shows up as zero or two low source drivers. It is visible in the first cycle in which the relays are enabled, and it stays visible until the next press or preset. A wrong tick count appears only at the power-up boundaries: the relays engage, or the mute lifts, one or more ticks early or late. It therefore takes a full sequence to expose, and the bench checks the cycle at each edge. Retained state after a power drop is hidden while the relays are off. It is checked at the ports only after the next `RELAY_TICKS` ticks.

// File: rtl/preamp_relay_pkg.sv
package preamp_relay_pkg;
    localparam int unsigned SRC_COUNT = 4;
    localparam int unsigned TGL_COUNT = 2;

    // bit positions in the source selection vector, lowest index = highest priority
    localparam int unsigned SRC_TUNER   = 0;
    localparam int unsigned SRC_AUX     = 1;
    localparam int unsigned SRC_PHONO   = 2;
    localparam int unsigned SRC_PHONO_SUB = 3;

    // bit positions in the toggle vector
    localparam int unsigned TGL_TONE = 0;
    localparam int unsigned TGL_TAPE = 1;

    typedef enum logic [1:0] {
        SEQ_OFF     = 2'd0,
        SEQ_WAIT    = 2'd1,
        SEQ_RELAYS  = 2'd2,
        SEQ_LIVE    = 2'd3
    } seq_phase_e;
endpackage

// File: rtl/prc_source_latch.sv
module prc_source_latch #(
    parameter int unsigned N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preset,
    input  logic [N_SRC-1:0] btn,
    output logic [N_SRC-1:0] sel
);
    localparam logic [N_SRC-1:0] PRESET_SEL = N_SRC'(1);

    typedef struct packed {
        logic [N_SRC-1:0] prev;
        logic [N_SRC-1:0] sel;
    } src_state_t;

    src_state_t st_d, st_q;
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] winner;

    always_comb begin
        rise   = btn & ~st_q.prev;
        // isolate the lowest set bit: fixed priority by index
        winner = rise & (~rise + N_SRC'(1));
        st_d      = st_q;
        st_d.prev = btn;
        if (preset) begin
            st_d.sel = PRESET_SEL;
        end else if (rise != '0) begin
            st_d.sel = winner;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= '0;
            st_q.sel  <= PRESET_SEL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel = st_q.sel;

    p_single_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.sel) == 1);

    p_select_pressed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset && $countones(rise) == 1) |=> (st_q.sel == $past(rise)));

    p_hold_selection_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset && rise == '0) |=> $stable(st_q.sel));

    p_lowest_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset && rise[0]) |=> st_q.sel[0]);

    p_preset_tuner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (st_q.sel == PRESET_SEL));
endmodule

// File: rtl/prc_toggle_bank.sv
module prc_toggle_bank #(
    parameter int unsigned N_TGL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preset,
    input  logic [N_TGL-1:0] btn,
    output logic [N_TGL-1:0] state
);
    typedef struct packed {
        logic [N_TGL-1:0] prev;
        logic [N_TGL-1:0] on;
    } tgl_state_t;

    tgl_state_t st_d, st_q;
    logic [N_TGL-1:0] rise;

    assign rise = btn & ~st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = btn;
        for (int i = 0; i < N_TGL; i++) begin
            if (preset) begin
                st_d.on[i] = 1'b0;
            end else if (rise[i]) begin
                st_d.on[i] = ~st_q.on[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q.on;

    for (genvar g = 0; g < N_TGL; g++) begin : g_chk
        p_flip_on_press_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!preset && rise[g]) |=> (st_q.on[g] != $past(st_q.on[g])));
        p_keep_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!preset && !rise[g]) |=> $stable(st_q.on[g]));
        p_preset_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
            preset |=> !st_q.on[g]);
    end
endmodule

// File: rtl/prc_power_seq.sv
module prc_power_seq
    import preamp_relay_pkg::*;
#(
    parameter int unsigned RELAY_TICKS  = 20,
    parameter int unsigned UNMUTE_TICKS = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic preset,
    input  logic pwr_good,
    input  logic tick,
    output logic relay_en,
    output logic mute
);
    localparam int unsigned CW = $clog2(UNMUTE_TICKS + 1);
    localparam logic [CW-1:0] RELAY_AT  = CW'(RELAY_TICKS);
    localparam logic [CW-1:0] UNMUTE_AT = CW'(UNMUTE_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        seq_phase_e    phase;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (preset || !pwr_good) begin
            st_d.cnt   = '0;
            st_d.phase = SEQ_OFF;
        end else begin
            if (tick && st_q.cnt != UNMUTE_AT) begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
            if (st_d.cnt >= UNMUTE_AT) begin
                st_d.phase = SEQ_LIVE;
            end else if (st_d.cnt >= RELAY_AT) begin
                st_d.phase = SEQ_RELAYS;
            end else begin
                st_d.phase = SEQ_WAIT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.phase <= SEQ_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign relay_en = (st_q.phase == SEQ_RELAYS) || (st_q.phase == SEQ_LIVE);
    assign mute     = (st_q.phase != SEQ_LIVE);

    p_unmute_needs_relays_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mute |-> relay_en);

    p_count_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= UNMUTE_AT);

    p_power_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (!relay_en && mute));

    p_preset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (!relay_en && mute && st_q.cnt == '0));

    p_no_tick_no_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && !preset && !tick) |=> $stable(st_q.cnt));
endmodule

// File: rtl/preamp_relay_ctrl.sv
module preamp_relay_ctrl
    import preamp_relay_pkg::*;
#(
    parameter int unsigned RELAY_TICKS  = 20,
    parameter int unsigned UNMUTE_TICKS = 22
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] btn_src,
    input  logic       btn_tone,
    input  logic       btn_tape,
    input  logic       pwr_good,
    input  logic       preset_req,
    input  logic       tick_1hz,
    output logic [3:0] src_drv_n,
    output logic       tone_drv_n,
    output logic       tape_drv_n,
    output logic       mute_on
);
    logic [SRC_COUNT-1:0] sel;
    logic [TGL_COUNT-1:0] tgl_btn;
    logic [TGL_COUNT-1:0] tgl_on;
    logic                 relay_en;

    assign tgl_btn[TGL_TONE] = btn_tone;
    assign tgl_btn[TGL_TAPE] = btn_tape;

    prc_source_latch #(.N_SRC(SRC_COUNT)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .preset (preset_req),
        .btn    (btn_src),
        .sel    (sel)
    );

    prc_toggle_bank #(.N_TGL(TGL_COUNT)) u_tgl (
        .clk    (clk),
        .rst_n  (rst_n),
        .preset (preset_req),
        .btn    (tgl_btn),
        .state  (tgl_on)
    );

    prc_power_seq #(
        .RELAY_TICKS  (RELAY_TICKS),
        .UNMUTE_TICKS (UNMUTE_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset   (preset_req),
        .pwr_good (pwr_good),
        .tick     (tick_1hz),
        .relay_en (relay_en),
        .mute     (mute_on)
    );

    // conducting driver = low output
    assign src_drv_n  = ~(sel & {SRC_COUNT{relay_en}});
    assign tone_drv_n = ~(tgl_on[TGL_TONE] & relay_en);
    assign tape_drv_n = ~(tgl_on[TGL_TAPE] & relay_en);

    p_driver_polarity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mute_on || ($countones(~src_drv_n) == 1));
endmodule

// File: tb/preamp_relay_ctrl_test.sv
module preamp_relay_ctrl_test;
    localparam int RT = 20;
    localparam int UT = 22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] btn_src = '0;
    logic       btn_tone = 1'b0, btn_tape = 1'b0;
    logic       pwr_good = 1'b0, preset_req = 1'b0, tick_1hz = 1'b0;
    logic [3:0] src_drv_n;
    logic       tone_drv_n, tape_drv_n, mute_on;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model
    logic [3:0] m_sel = 4'b0001;
    logic       m_tone = 1'b0, m_tape = 1'b0;
    logic [5:0] m_prev = '0;
    int         m_cnt = 0;

    always #10 clk = ~clk;

    preamp_relay_ctrl #(.RELAY_TICKS(RT), .UNMUTE_TICKS(UT)) uut (
        .clk(clk), .rst_n(rst_n), .btn_src(btn_src), .btn_tone(btn_tone),
        .btn_tape(btn_tape), .pwr_good(pwr_good), .preset_req(preset_req),
        .tick_1hz(tick_1hz), .src_drv_n(src_drv_n), .tone_drv_n(tone_drv_n),
        .tape_drv_n(tape_drv_n), .mute_on(mute_on)
    );

    function automatic logic [3:0] lowest_bit(input logic [3:0] v);
        for (int i = 0; i < 4; i++) if (v[i]) return 4'(1 << i);
        return 4'b0;
    endfunction

    function automatic logic [3:0] exp_src();
        return (m_cnt >= RT) ? ~m_sel : 4'hF;
    endfunction

    function automatic logic exp_tgl(input logic on);
        return ~(on && (m_cnt >= RT));
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [5:0] now;
        logic [3:0] rise;
        now  = {btn_tape, btn_tone, btn_src};
        rise = btn_src & ~m_prev[3:0];
        if (preset_req) begin
            m_sel = 4'b0001; m_tone = 1'b0; m_tape = 1'b0; m_cnt = 0;
        end else begin
            if (rise != 0) m_sel = lowest_bit(rise);
            if (btn_tone && !m_prev[4]) m_tone = ~m_tone;
            if (btn_tape && !m_prev[5]) m_tape = ~m_tape;
            if (!pwr_good) m_cnt = 0;
            else if (tick_1hz && m_cnt < UT) m_cnt++;
        end
        m_prev = now;
    endtask

    // one clock: inputs were set before the call, outputs compared after the edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R2 source drivers", src_drv_n, exp_src());
        chk("R5 tone driver", {3'b0, tone_drv_n}, {3'b0, exp_tgl(m_tone)});
        chk("R5 tape driver", {3'b0, tape_drv_n}, {3'b0, exp_tgl(m_tape)});
        chk("R9 mute", {3'b0, mute_on}, {3'b0, logic'(m_cnt < UT)});
    endtask

    task automatic run_ticks(input int n);
        tick_1hz = 1'b1;
        for (int i = 0; i < n; i++) step();
        tick_1hz = 1'b0;
    endtask

    task automatic press_src(input logic [3:0] b);
        btn_src = b; step();
        btn_src = '0; step();
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7/R11 reset state: relays released, muted
        chk("R7 reset source drivers", src_drv_n, 4'hF);
        chk("R11 reset mute", {3'b0, mute_on}, 4'b0001);

        // R8: power-up boundary
        pwr_good = 1'b1;
        run_ticks(RT - 1);
        chk("R8 before relay delay", src_drv_n, 4'hF);
        run_ticks(1);
        chk("R8 relays engage, R1 tuner preset", src_drv_n, 4'b1110);
        chk("R9 still muted in gap", {3'b0, mute_on}, 4'b0001);
        run_ticks(UT - RT - 1);
        chk("R9 mute held one tick before", {3'b0, mute_on}, 4'b0001);
        run_ticks(1);
        chk("R9 mute released", {3'b0, mute_on}, 4'b0000);

        // R2 select aux, R3 hold and release
        btn_src = 4'b0010; step();
        chk("R2 aux selected", src_drv_n, 4'b1101);
        step(); step();
        chk("R3 held button no change", src_drv_n, 4'b1101);
        btn_src = 4'b0110; step();
        chk("R2 phono added while aux held", src_drv_n, 4'b1011);
        btn_src = '0; step();
        chk("R3 falling edge no change", src_drv_n, 4'b1011);

        // R4 simultaneous rises
        press_src(4'b1010);
        chk("R4 aux beats subsonic", src_drv_n, 4'b1101);
        press_src(4'b1111);
        chk("R4 tuner beats all", src_drv_n, 4'b1110);
        press_src(4'b1000);
        chk("R2 subsonic selected", src_drv_n, 4'b0111);

        // R5 toggles, R6 polarity
        btn_tone = 1'b1; step(); step();
        chk("R6 tone on drives low", {3'b0, tone_drv_n}, 4'b0000);
        chk("R5 tape untouched", {3'b0, tape_drv_n}, 4'b0001);
        btn_tone = 1'b0; btn_tape = 1'b1; step();
        chk("R5 tape on", {3'b0, tape_drv_n}, 4'b0000);
        btn_tape = 1'b0; btn_tone = 1'b1; step();
        chk("R5 tone off on second press", {3'b0, tone_drv_n}, 4'b0001);
        btn_tone = 1'b0; step();

        // R10 power drop and retention
        pwr_good = 1'b0; step();
        chk("R10 drivers released", src_drv_n, 4'hF);
        chk("R10 tape released", {3'b0, tape_drv_n}, 4'b0001);
        chk("R10 muted", {3'b0, mute_on}, 4'b0001);
        pwr_good = 1'b1;
        run_ticks(RT);
        chk("R10 selection retained", src_drv_n, 4'b0111);
        chk("R10 tape retained", {3'b0, tape_drv_n}, 4'b0000);
        run_ticks(UT - RT);

        // R11 / R7 preset request, with a press in the same cycle ignored
        preset_req = 1'b1; btn_src = 4'b0100; btn_tone = 1'b1; step();
        chk("R11 relays released during preset", src_drv_n, 4'hF);
        chk("R11 muted during preset", {3'b0, mute_on}, 4'b0001);
        step();
        preset_req = 1'b0; btn_src = '0; btn_tone = 1'b0; step();
        run_ticks(RT);
        chk("R7 tuner after preset", src_drv_n, 4'b1110);
        chk("R7 tone off after preset", {3'b0, tone_drv_n}, 4'b0001);
        chk("R7 tape off after preset", {3'b0, tape_drv_n}, 4'b0001);

        // constrained random phase
        for (int k = 0; k < 4000; k++) begin
            if ($urandom % 4 == 0) btn_src = 4'($urandom);
            else if ($urandom % 3 == 0) btn_src = '0;
            if ($urandom % 5 == 0) btn_tone = 1'($urandom);
            if ($urandom % 5 == 0) btn_tape = 1'($urandom);
            if ($urandom % 300 == 0) pwr_good = 1'b0;
            else if ($urandom % 15 == 0) pwr_good = 1'b1;
            preset_req = ($urandom % 400 == 0);
            tick_1hz = 1'($urandom);
            step();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule